// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Flush Engine

This block sits between a processor's single-word load/store port and an external memory that moves whole lines in bursts. It is two-way set-associative and write-back: stores only change the cached copy and mark the line dirty. A dirty line reaches memory only when it is evicted or when a flush writes it out. On a miss, a dirty victim is first written back in one burst, then the new line is fetched, and then the original access completes. The processor is stalled throughout.

Some other agent, such as a display scanner, reads memory directly. To keep memory current for that reader, a flush engine cleans dirty lines. There are three triggers. A software pulse starts a full pass. The rising edge of a frame-sync input starts a full pass when that trigger is enabled. A free-running timer cleans one line per period, moving a round-robin pointer over all lines. A full pass visits sets in ascending order, and both ways within a set. It writes back only dirty lines and leaves every line valid. A full-pass request that arrives while a pass is running is held and served afterwards.

With the default parameters the block holds 128 sets of 16-word lines. The 64 KB organisation with 256-byte lines is the setting `LINE_WORDS=64`, `SETS=128`.

Top module: `wb_cache`

## Requirements
- R1: Every load returns the value of the most recent store to the same word address, or the memory's value if that word was never stored, under any sequence of addresses. The cache has 2 ways of `SETS` sets of `LINE_WORDS` words. Word address bits [OFF-1:0] pick the word, the next `log2(SETS)` bits pick the set, and the upper bits form the tag.
- R2: A store does not change external memory. Memory receives the new value only through an eviction or a flush.
- R3: Each set keeps one replacement bit, updated on every hit, including the hit that ends a miss. A miss replaces the way that was not used most recently.
- R4: A miss whose victim is valid and dirty proceeds in three steps. First one write burst of `LINE_WORDS` words goes to the victim's own line address. Then one read burst fetches the requested line. Then the access completes.
- R5: A load or store that hits issues no memory command. A miss issues exactly one read burst.
- R6: A pulse on `flush_req` writes every dirty line back. Afterwards memory equals the processor's view, and the flushed lines still hit.
- R7: A full pass skips clean lines and costs one cycle per clean line. A pass over a clean cache issues no write burst and keeps `cpu_busy` high for `2*SETS` cycles.
- R8: While `vsync_en` is high, a rising edge on `vsync` starts a full pass. While `vsync_en` is low, `vsync` is ignored.
- R9: While `auto_en` is high, one line is examined every `AUTO_PERIOD` cycles and written back if it is dirty. The line pointer walks all `2*SETS` lines and wraps. While `auto_en` is low, no automatic writeback happens.
- R10: A full-pass request that arrives while a pass runs is held. A second full pass runs right after the first one.
- R11: `cpu_busy` is low after reset. It is high from the cycle after an accepted request until the cycle in which `cpu_ack` pulses. In that cycle `cpu_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken while `cpu_busy` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Stall indication |
| flush_req | input | 1 | Software full-flush pulse |
| vsync | input | 1 | Frame sync; a rising edge is the trigger |
| vsync_en | input | 1 | Enables the frame-sync trigger |
| auto_en | input | 1 | Enables the periodic one-line clean |
| mem_cmd_valid | output | 1 | One-cycle burst command |
| mem_cmd_we | output | 1 | 1 = write burst, 0 = read burst |
| mem_cmd_line | output | ADDR_W-log2(LINE_WORDS) | Line address of the burst |
| mem_wvalid | output | 1 | Write beat valid; beats follow the command in order |
| mem_wdata | output | DATA_W | Write beat data |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data, word 0 first |

## Verification
Single-line patterns check the hit and miss command counts. A three-tag pattern on one set sets an older line against a more recently used one, which shows whether the victim choice and the writeback target follow the replacement bit. A store-to-every-address sweep over a small configuration fills and evicts every line repeatedly, which separates correct tag and data bookkeeping from aliasing faults. The flush triggers are separated by their effects: memory contents, the number of write bursts, and the number of busy cycles. The busy-cycle count is what shows that a request held during a pass gets a second pass of its own.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_RDOUT, ST_WB, ST_FILL, ST_FSCAN
  } cache_state_t;

  // where a writeback returns to when its burst is done
  typedef enum logic [1:0] {
    RET_FILL, RET_FSCAN, RET_IDLE
  } wb_ret_t;
endpackage

// File: rtl/cache_data_ram.sv
module cache_data_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-first single port, one cycle latency
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/cache_flush_sched.sv
module cache_flush_sched #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_req,
  input  logic vsync,
  input  logic vsync_en,
  input  logic auto_en,
  input  logic full_start,
  input  logic auto_take,
  output logic full_pend,
  output logic auto_pend
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic          vs_q;
  logic [CW-1:0] tmr;
  logic          tick;

  assign tick = (tmr == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q      <= 1'b0;
      tmr       <= '0;
      full_pend <= 1'b0;
      auto_pend <= 1'b0;
    end else begin
      vs_q <= vsync;
      tmr  <= tick ? '0 : tmr + 1'b1;
      // a new request wins over the clear, so nothing is dropped
      if (sw_req || (vsync_en && vsync && !vs_q)) full_pend <= 1'b1;
      else if (full_start)                        full_pend <= 1'b0;
      if (!auto_en)       auto_pend <= 1'b0;
      else if (tick)      auto_pend <= 1'b1;
      else if (auto_take) auto_pend <= 1'b0;
    end
  end

  // R10: a pending full pass is only cleared by starting it
  assert_pend_held_R10: assert property (@(posedge clk) disable iff (rst)
    (full_pend && !full_start) |=> full_pend);

  // R9: the auto request is never raised while disabled
  assert_auto_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> !auto_pend);
endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 32,
  parameter int SETS        = 128,
  parameter int LINE_WORDS  = 16,
  parameter int AUTO_PERIOD = 1024
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cpu_req,
  input  logic                                 cpu_we,
  input  logic [ADDR_W-1:0]                    cpu_addr,
  input  logic [DATA_W-1:0]                    cpu_wdata,
  output logic [DATA_W-1:0]                    cpu_rdata,
  output logic                                 cpu_ack,
  output logic                                 cpu_busy,
  input  logic                                 flush_req,
  input  logic                                 vsync,
  input  logic                                 vsync_en,
  input  logic                                 auto_en,
  output logic                                 mem_cmd_valid,
  output logic                                 mem_cmd_we,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] mem_cmd_line,
  output logic                                 mem_wvalid,
  output logic [DATA_W-1:0]                    mem_wdata,
  input  logic                                 mem_rvalid,
  input  logic [DATA_W-1:0]                    mem_rdata
);
  localparam int SET_W  = $clog2(SETS);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int RAM_AW = SET_W + OFF_W;
  localparam int PTR_W  = SET_W + 1;
  localparam logic [PTR_W-1:0] LAST_LINE = PTR_W'(2 * SETS - 1);

  cache_state_t state;
  wb_ret_t      wb_ret, go_ret;

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [SETS-1:0]  val_q [2];
  logic [SETS-1:0]  dirty_q [2];
  logic [SETS-1:0]  lru_q;            // way to replace next

  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [SET_W-1:0]  r_set;
  logic [OFF_W-1:0]  r_off;
  logic [TAG_W-1:0]  r_tag;
  assign r_off = r_addr[OFF_W-1:0];
  assign r_set = r_addr[OFF_W +: SET_W];
  assign r_tag = r_addr[ADDR_W-1 -: TAG_W];

  logic [SET_W-1:0] wb_set, go_set;
  logic             wb_way, go_way, go_wb, fill_way;
  logic [OFF_W:0]   wb_cnt, wb_sent;
  logic             rd_v, wb_issuing, wb_last;
  logic [OFF_W-1:0] fill_cnt;
  logic [PTR_W-1:0] fptr, aptr;

  logic full_pend, auto_pend, full_start, auto_take;
  logic hit0, hit1, hit_any, hit_way;

  logic [RAM_AW-1:0] ram_addr [2];
  logic              ram_we   [2];
  logic [DATA_W-1:0] ram_wd   [2];
  logic [DATA_W-1:0] ram_q    [2];

  assign hit0    = val_q[0][r_set] && (tag_q[0][r_set] == r_tag);
  assign hit1    = val_q[1][r_set] && (tag_q[1][r_set] == r_tag);
  assign hit_any = hit0 || hit1;
  assign hit_way = hit1;

  assign wb_issuing = (state == ST_WB) && !wb_cnt[OFF_W];
  assign wb_last    = rd_v && (wb_sent == (OFF_W+1)'(LINE_WORDS - 1));
  assign cpu_busy   = (state != ST_IDLE);

  assign full_start = (state == ST_IDLE) && !cpu_req && full_pend;
  assign auto_take  = (state == ST_IDLE) && !cpu_req && !full_pend && auto_pend;

  cache_flush_sched #(.PERIOD(AUTO_PERIOD)) sched_i (
    .clk(clk), .rst(rst), .sw_req(flush_req), .vsync(vsync),
    .vsync_en(vsync_en), .auto_en(auto_en), .full_start(full_start),
    .auto_take(auto_take), .full_pend(full_pend), .auto_pend(auto_pend)
  );

  for (genvar w = 0; w < 2; w++) begin : g_way
    always_comb begin
      ram_addr[w] = {r_set, r_off};
      ram_we[w]   = 1'b0;
      ram_wd[w]   = r_wdata;
      case (state)
        ST_LOOKUP: ram_we[w] = r_we && (w == 0 ? hit0 : hit1);
        ST_WB:     ram_addr[w] = {wb_set, wb_cnt[OFF_W-1:0]};
        ST_FILL: begin
          ram_addr[w] = {r_set, fill_cnt};
          ram_wd[w]   = mem_rdata;
          ram_we[w]   = mem_rvalid && (fill_way == 1'(w));
        end
        default: ;
      endcase
    end

    cache_data_ram #(.AW(RAM_AW), .DW(DATA_W)) ram_i (
      .clk(clk), .we(ram_we[w]), .addr(ram_addr[w]),
      .wdata(ram_wd[w]), .q(ram_q[w])
    );
  end

  // decides whether this cycle launches a writeback burst
  always_comb begin
    go_wb  = 1'b0;
    go_set = r_set;
    go_way = lru_q[r_set];
    go_ret = RET_FILL;
    case (state)
      ST_IDLE: if (auto_take && val_q[aptr[0]][aptr[PTR_W-1:1]]
                   && dirty_q[aptr[0]][aptr[PTR_W-1:1]]) begin
        go_wb = 1'b1; go_set = aptr[PTR_W-1:1]; go_way = aptr[0]; go_ret = RET_IDLE;
      end
      ST_LOOKUP: if (!hit_any && val_q[lru_q[r_set]][r_set]
                     && dirty_q[lru_q[r_set]][r_set]) go_wb = 1'b1;
      ST_FSCAN: if (val_q[fptr[0]][fptr[PTR_W-1:1]]
                    && dirty_q[fptr[0]][fptr[PTR_W-1:1]]) begin
        go_wb = 1'b1; go_set = fptr[PTR_W-1:1]; go_way = fptr[0]; go_ret = RET_FSCAN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      val_q[0]      <= '0;
      val_q[1]      <= '0;
      dirty_q[0]    <= '0;
      dirty_q[1]    <= '0;
      lru_q         <= '0;
      fptr          <= '0;
      aptr          <= '0;
      rd_v          <= 1'b0;
      cpu_ack       <= 1'b0;
      cpu_rdata     <= '0;
      mem_cmd_valid <= 1'b0;
      mem_cmd_we    <= 1'b0;
      mem_cmd_line  <= '0;
      mem_wvalid    <= 1'b0;
      mem_wdata     <= '0;
    end else begin
      cpu_ack       <= 1'b0;
      mem_cmd_valid <= 1'b0;
      rd_v          <= wb_issuing;
      mem_wvalid    <= rd_v;
      mem_wdata     <= ram_q[wb_way];
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            r_we <= cpu_we; r_addr <= cpu_addr; r_wdata <= cpu_wdata;
            state <= ST_LOOKUP;
          end else if (full_pend) begin
            fptr  <= '0;
            state <= ST_FSCAN;
          end else if (auto_pend) begin
            aptr <= (aptr == LAST_LINE) ? '0 : aptr + 1'b1;
          end
        end
        ST_LOOKUP: begin
          if (hit_any) begin
            lru_q[r_set] <= ~hit_way;
            if (r_we) begin
              dirty_q[hit_way][r_set] <= 1'b1;
              cpu_ack <= 1'b1;
              state   <= ST_IDLE;
            end else state <= ST_RDOUT;
          end else begin
            fill_way <= lru_q[r_set];
            if (!go_wb) begin
              mem_cmd_valid <= 1'b1; mem_cmd_we <= 1'b0;
              mem_cmd_line  <= r_addr[ADDR_W-1:OFF_W];
              fill_cnt <= '0;
              state    <= ST_FILL;
            end
          end
        end
        ST_RDOUT: begin
          cpu_rdata <= ram_q[hit_way];
          cpu_ack   <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_WB: begin
          if (wb_issuing) wb_cnt <= wb_cnt + 1'b1;
          if (rd_v)       wb_sent <= wb_sent + 1'b1;
          if (wb_last) begin
            dirty_q[wb_way][wb_set] <= 1'b0;
            case (wb_ret)
              RET_FILL: begin
                mem_cmd_valid <= 1'b1; mem_cmd_we <= 1'b0;
                mem_cmd_line  <= r_addr[ADDR_W-1:OFF_W];
                fill_cnt <= '0;
                state    <= ST_FILL;
              end
              RET_FSCAN: begin
                if (fptr == LAST_LINE) state <= ST_IDLE;
                else begin fptr <= fptr + 1'b1; state <= ST_FSCAN; end
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_FILL: if (mem_rvalid) begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == OFF_W'(LINE_WORDS - 1)) begin
            tag_q[fill_way][r_set]   <= r_tag;
            val_q[fill_way][r_set]   <= 1'b1;
            dirty_q[fill_way][r_set] <= 1'b0;
            state <= ST_LOOKUP;
          end
        end
        ST_FSCAN: if (!go_wb) begin
          if (fptr == LAST_LINE) state <= ST_IDLE;
          else fptr <= fptr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      if (go_wb) begin
        wb_set  <= go_set;
        wb_way  <= go_way;
        wb_ret  <= go_ret;
        wb_cnt  <= '0;
        wb_sent <= '0;
        mem_cmd_valid <= 1'b1;
        mem_cmd_we    <= 1'b1;
        mem_cmd_line  <= {tag_q[go_way][go_set], go_set};
        state <= ST_WB;
      end
    end
  end

  // R11: completion coincides with the end of the stall
  assert_ack_ends_busy_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> (!cpu_busy && $past(cpu_busy)));

  // R5: burst commands are only issued while the processor is stalled
  assert_cmd_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_cmd_valid |-> cpu_busy);

  // R6: the line is clean once its writeback burst has been sent
  assert_clean_after_wb_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB && wb_last) |=> !dirty_q[wb_way][wb_set]);

  // R1: a tag never matches in both ways of a set
  assert_single_hit_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOKUP) |-> $onehot0({hit1, hit0}));
endmodule

// File: tb/wb_cache_tb.sv
module wb_cache_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int LW = 4;
  localparam int AP = 64;
  localparam int NWORDS = 1 << AW;
  localparam int LNW = AW - $clog2(LW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_ack, cpu_busy;
  logic          flush_req = 0, vsync = 0, vsync_en = 0, auto_en = 0;
  logic          mem_cmd_valid, mem_cmd_we, mem_wvalid;
  logic [LNW-1:0] mem_cmd_line;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid;
  logic [DW-1:0] mem_rdata;

  wb_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .LINE_WORDS(LW),
             .AUTO_PERIOD(AP)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ack(cpu_ack), .cpu_busy(cpu_busy), .flush_req(flush_req),
    .vsync(vsync), .vsync_en(vsync_en), .auto_en(auto_en),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_we(mem_cmd_we),
    .mem_cmd_line(mem_cmd_line), .mem_wvalid(mem_wvalid),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_val(int a);
    return 32'hA500_0000 ^ a;
  endfunction

  // burst memory model
  logic [DW-1:0]  mem [NWORDS];
  logic [LNW-1:0] wr_line, rd_line;
  int wr_beat, rd_beat, rd_wait, n_wr, n_rd;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= init_val(i);
      n_wr <= 0; n_rd <= 0; rd_wait <= 0; rd_beat <= LW; wr_beat <= 0;
    end else begin
      if (mem_cmd_valid && mem_cmd_we) begin
        wr_line <= mem_cmd_line; wr_beat <= 0; n_wr <= n_wr + 1;
      end
      if (mem_wvalid) begin
        mem[{wr_line, 2'(wr_beat)}] <= mem_wdata;
        wr_beat <= wr_beat + 1;
      end
      if (mem_cmd_valid && !mem_cmd_we) begin
        rd_line <= mem_cmd_line; rd_beat <= 0; rd_wait <= 3; n_rd <= n_rd + 1;
      end else if (rd_wait > 0) rd_wait <= rd_wait - 1;
      else if (rd_beat < LW) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[{rd_line, 2'(rd_beat)}];
        rd_beat    <= rd_beat + 1;
      end
    end
  end

  logic [DW-1:0] golden [NWORDS];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic we, int a, logic [DW-1:0] wd, output logic [DW-1:0] rd);
    logic busy_ok;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    busy_ok = cpu_busy;
    while (!cpu_ack) begin
      busy_ok &= cpu_busy;
      @(negedge clk);
    end
    busy_ok &= !cpu_busy;
    rd = cpu_rdata;
    if (we) golden[a] = wd;
    chk("R11 busy until ack", {31'b0, busy_ok}, 32'd1);
  endtask

  task automatic rd_chk(string req, int a);
    logic [DW-1:0] v;
    access(1'b0, a, '0, v);
    chk(req, v, golden[a]);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    logic [DW-1:0] v;
    access(1'b1, a, d, v);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (cpu_busy) @(negedge clk);
  endtask

  task automatic mem_match(string req);
    int miss = 0;
    for (int i = 0; i < NWORDS; i++) if (mem[i] !== golden[i]) miss++;
    chk(req, miss, 0);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_req = 1;
    @(negedge clk); flush_req = 0;
  endtask

  function automatic logic [DW-1:0] pat(int a, int r);
    return 32'h1357_0000 ^ (a * 32'h0001_0101) ^ (r << 28);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, r0, n1, cnt;
    logic [DW-1:0] v;
    for (int i = 0; i < NWORDS; i++) golden[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset busy", {31'b0, cpu_busy}, 0);
    chk("R11 reset ack", {31'b0, cpu_ack}, 0);

    // R5: miss fetches once, same-line load hits
    r0 = n_rd;
    rd_chk("R5 miss data", 'h005);
    chk("R5 one read burst on miss", n_rd - r0, 1);
    rd_chk("R5 hit data", 'h006);
    chk("R5 no command on hit", n_rd - r0, 1);

    // R2: store stays in the cache
    w0 = n_wr;
    wr('h005, 32'hDEAD_0005);
    chk("R2 no write burst on store", n_wr - w0, 0);
    chk("R2 memory unchanged", mem['h005], init_val('h005));
    rd_chk("R1 load after store", 'h005);

    // R3/R4: three tags on set 2
    wr('h018, 32'hAAAA_0018);
    wr('h028, 32'hBBBB_0028);
    rd_chk("R3 hit older line", 'h018);
    w0 = n_wr;
    rd_chk("R4 load after dirty eviction", 'h038);
    chk("R4 one writeback burst", n_wr - w0, 1);
    chk("R3 less recent line evicted", mem['h028], 32'hBBBB_0028);
    chk("R3 recent line kept", mem['h018], init_val('h018));
    rd_chk("R4 evicted line refetched", 'h028);
    chk("R3 second victim written", mem['h018], 32'hAAAA_0018);

    // R6: software flush
    wr('h041, 32'h0000_0041);
    wr('h07F, 32'h0000_007F);
    pulse_flush();
    wait_idle();
    mem_match("R6 memory equals cache view");
    r0 = n_rd;
    rd_chk("R6 flushed line still valid", 'h07F);
    chk("R6 no refetch after flush", n_rd - r0, 0);

    // R7: flush of a clean cache
    w0 = n_wr;
    pulse_flush();
    n1 = 0;
    repeat (40) begin @(negedge clk); if (cpu_busy) n1++; end
    chk("R7 no writes for clean lines", n_wr - w0, 0);
    chk("R7 one cycle per clean line", n1, 2 * NS);

    // R8: frame sync trigger
    wr('h0C3, 32'hC0C0_00C3);
    @(negedge clk); vsync = 1; @(negedge clk); vsync = 0;
    repeat (30) @(negedge clk);
    chk("R8 sync ignored when disabled", mem['h0C3], init_val('h0C3));
    vsync_en = 1;
    @(negedge clk); vsync = 1; @(negedge clk); vsync = 0;
    wait_idle();
    chk("R8 sync flush", mem['h0C3], 32'hC0C0_00C3);

    // R10: sync edge during a running pass
    pulse_flush();
    @(negedge clk); vsync = 1; @(negedge clk); vsync = 0;
    cnt = 2;
    repeat (50) begin @(negedge clk); if (cpu_busy) cnt++; end
    chk("R10 held request gives second pass", cnt, 2 * n1);
    vsync_en = 0;

    // R1: sweep over every word, two rounds
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < NWORDS; a++) wr(a, pat(a, r));
      for (int a = 0; a < NWORDS; a += 3) rd_chk("R1 sweep load", a);
    end
    pulse_flush();
    wait_idle();
    mem_match("R1 sweep memory after flush");

    // R9: periodic clean
    for (int a = 0; a < 32; a++) wr(a, pat(a, 5));
    w0 = n_wr;
    repeat (300) @(negedge clk);
    chk("R9 no auto clean when disabled", n_wr - w0, 0);
    auto_en = 1;
    repeat (130) @(negedge clk);
    cnt = n_wr - w0;
    chk("R9 one line per period", {31'b0, (cnt >= 1 && cnt <= 3)}, 1);
    repeat (2 * NS * AP + 2 * AP) @(negedge clk);
    chk("R9 every dirty line cleaned once", n_wr - w0, 2 * NS);
    mem_match("R9 memory coherent after auto clean");
    auto_en = 0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule